// File: doc/BRIEF.md
# Keyed Configuration Lock Controller

This block owns a single protection bit that a neighbouring register file reads to decide whether its remap registers accept writes. While the bit is set, those writes are dropped silently: the bus cycle still completes, but nothing changes. The bit itself cannot be written directly. Software first has to present a two-byte key on the control-byte write port. Only the control write that comes next may set or clear the bit.

A one-way policy input stops the bit from being cleared once it has been set, even when the key is correct. This limits software to a single configuration session. The policy is active when the input is high, which is its unprogrammed default. After a keyed update the bit keeps its value until another keyed write changes it. There is no automatic relock. All other bits of the control byte belong to other logic and are ignored here.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset `locked` is 0 and the key detector is idle. A control write with bit 6 set that arrives straight after reset leaves `locked` at 0.
- R2: A control write (`ctl_sel` and `ctl_wr` both high in the same cycle) of 0x46, followed by a control write of 0x57, opens the update window. The next control write then loads bit 6 of `ctl_wdata` into `locked`, visible from the clock edge that takes that write.
- R3: With `one_way` low, a keyed update write with bit 6 at 0 clears `locked`.
- R4: The window covers exactly one control write. That write is consumed even when it leaves `locked` unchanged, and any later control write without a new key has no effect.
- R5: `locked` changes only on the edge that takes a keyed update write. Cycles with no control write never change it.
- R6: Any control write of a wrong value while the detector waits for a key byte returns the detector to idle. This includes a second 0x46 while 0x57 is expected, so only the exact pair 0x46 then 0x57 opens the window.
- R7: With `one_way` high, a set `locked` stays set through any keyed write. A clear `locked` can still be set by a keyed write.
- R8: Only bit 6 of the update write matters. The other seven bits of that byte have no effect on `locked`.
- R9: Cycles without a control write, including writes with `ctl_sel` low, neither advance nor reset the detector. Idle cycles may sit between the key bytes, and between the key and the update write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sel | input | 1 | Selects the control byte for the current write |
| ctl_wr | input | 1 | Write strobe |
| ctl_wdata | input | 8 | Write data for the control byte |
| one_way | input | 1 | High forbids clearing the lock once it is set |
| locked | output | 1 | Current lock state; high means the remap registers refuse writes |

## Verification
The hardest situation to reach is a near miss on the key. These cases differ from a correct sequence in only one byte, or in where a single write falls: a wrong first byte, a wrong second byte such as a repeated 0x46, or a second write inside the window. The bench sweeps all 256 values into each key position and into the update byte. Each trial is followed by a probe update of 0x40, so that a window left open by mistake shows up on `locked`. A correct keyed clear then returns the block to a known state for the next trial.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_ARMED = 2'd1,
      KS_OPEN  = 2'd2
   } key_state_t;

endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
   import cfg_lock_pkg::*;
#(
   parameter int unsigned          DATA_W = 8,
   parameter logic [DATA_W-1:0]    KEY_A  = 8'h46,
   parameter logic [DATA_W-1:0]    KEY_B  = 8'h57
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              upd_stb
);

   key_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_stb) begin
         unique case (state_q)
            KS_IDLE:  state_d = (wr_data == KEY_A) ? KS_ARMED : KS_IDLE;
            KS_ARMED: state_d = (wr_data == KEY_B) ? KS_OPEN  : KS_IDLE;
            KS_OPEN:  state_d = KS_IDLE;
            default:  state_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign upd_stb = wr_stb && (state_q == KS_OPEN);

   AST_WINDOW_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && state_q == KS_OPEN) |=> (state_q == KS_IDLE)); // R4

   AST_OPEN_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_OPEN && $past(state_q) != KS_OPEN) |-> ($past(state_q) == KS_ARMED && $past(wr_stb))); // R2

   AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(state_q)); // R9

endmodule

// File: rtl/cfg_lock_bit.sv
module cfg_lock_bit #(
   parameter bit ONE_WAY_EN  = 1'b1,
   parameter bit RESET_VALUE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_stb,
   input  logic req_bit,
   input  logic one_way,
   output logic locked
);

   logic hold_set;
   logic lock_q;

   generate
      if (ONE_WAY_EN) begin : g_one_way
         assign hold_set = lock_q & one_way;

         AST_ONE_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(lock_q) && $past(one_way)) |-> lock_q); // R7
      end else begin : g_free
         logic unused_one_way;
         assign unused_one_way = one_way;
         assign hold_set = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       lock_q <= RESET_VALUE;
      else if (upd_stb) lock_q <= req_bit | hold_set;
   end

   assign locked = lock_q;

   AST_LOCK_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_q) |-> $past(upd_stb)); // R5

endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned LOCK_POS   = 6,
   parameter logic [7:0]  KEY_A      = 8'h46,
   parameter logic [7:0]  KEY_B      = 8'h57,
   parameter bit          ONE_WAY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_sel,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              one_way,
   output logic              locked
);

   localparam logic [DATA_W-1:0] KEY_A_W = DATA_W'(KEY_A);
   localparam logic [DATA_W-1:0] KEY_B_W = DATA_W'(KEY_B);

   generate
      if (LOCK_POS >= DATA_W) begin : g_bad_pos
         $error("cfg_lock_guard: LOCK_POS outside the control byte");
      end
      if (KEY_A == KEY_B) begin : g_bad_key
         $error("cfg_lock_guard: key bytes must differ");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("cfg_lock_guard: DATA_W must hold a full key byte");
      end
   endgenerate

   logic wr_stb;
   logic upd_stb;

   assign wr_stb = ctl_sel & ctl_wr;

   cfg_key_detect #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A_W),
      .KEY_B  (KEY_B_W)
   ) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_data (ctl_wdata),
      .upd_stb (upd_stb)
   );

   cfg_lock_bit #(
      .ONE_WAY_EN  (ONE_WAY_EN),
      .RESET_VALUE (1'b0)
   ) u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_stb (upd_stb),
      .req_bit (ctl_wdata[LOCK_POS]),
      .one_way (one_way),
      .locked  (locked)
   );

   AST_NO_CHANGE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_sel && ctl_wr) |=> $stable(locked)); // R5

endmodule

// File: tb/cfg_lock_guard_tb.sv
module cfg_lock_guard_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_sel = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       one_way = 1'b0;
   logic       locked;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_lock_guard u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_sel   (ctl_sel),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .one_way   (one_way),
      .locked    (locked)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: locked=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic put(input logic [7:0] d, input logic sel);
      @(negedge clk);
      ctl_sel = sel; ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_sel = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic keyed(input logic [7:0] d);
      put(8'h46, 1'b1);
      put(8'h57, 1'b1);
      put(d, 1'b1);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state, and a direct write cannot lock
      check(locked, 1'b0, "R1");
      put(8'h40, 1'b1);
      check(locked, 1'b0, "R1");

      // R2 / R6: sweep the first key byte
      for (int i = 0; i < 256; i++) begin
         put(8'(i), 1'b1);
         put(8'h57, 1'b1);
         put(8'h40, 1'b1);
         check(locked, (i == 8'h46), "R6");
         if (locked) begin
            keyed(8'h00);
            check(locked, 1'b0, "R3");
         end
      end

      // R6: sweep the second key byte
      for (int j = 0; j < 256; j++) begin
         put(8'h46, 1'b1);
         put(8'(j), 1'b1);
         put(8'h40, 1'b1);
         check(locked, (j == 8'h57), "R6");
         if (locked) begin
            keyed(8'h00);
            check(locked, 1'b0, "R3");
         end
      end

      // R8 / R2: sweep the update byte
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(v);
         keyed(b);
         check(locked, b[6], "R8");
         keyed(8'h00);
         check(locked, 1'b0, "R3");
      end

      // R4: a second write after the window is closed has no effect
      keyed(8'h40);
      check(locked, 1'b1, "R2");
      put(8'h00, 1'b1);
      check(locked, 1'b1, "R4");
      keyed(8'h00);
      check(locked, 1'b0, "R3");
      // R4: a no-change update write still consumes the window
      keyed(8'h05);
      check(locked, 1'b0, "R4");
      put(8'h40, 1'b1);
      check(locked, 1'b0, "R4");

      // R9: idle cycles and deselected writes do not disturb the key
      put(8'h46, 1'b1);
      idle(3);
      put(8'h00, 1'b0);
      put(8'h57, 1'b1);
      idle(4);
      put(8'h13, 1'b0);
      put(8'h40, 1'b1);
      check(locked, 1'b1, "R9");
      // R5: lock holds across many quiet cycles
      idle(20);
      check(locked, 1'b1, "R5");
      put(8'h00, 1'b0);
      check(locked, 1'b1, "R5");
      keyed(8'h00);
      check(locked, 1'b0, "R3");

      // R7: one-way policy
      one_way = 1'b1;
      keyed(8'h00);
      check(locked, 1'b0, "R7");
      keyed(8'h40);
      check(locked, 1'b1, "R7");
      keyed(8'h00);
      check(locked, 1'b1, "R7");
      keyed(8'hBF);
      check(locked, 1'b1, "R7");
      keyed(8'h40);
      check(locked, 1'b1, "R7");

      // R1: reset clears the lock even under the one-way policy
      do_reset();
      check(locked, 1'b0, "R1");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule